// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block keeps the bookkeeping for a ring of register windows. It holds four occupancy counters, the current window index and a small trap-vector selector word. The counters are: windows free to be saved into, windows holding restorable frames, windows owned by another context, and windows known to be clean. Five window commands arrive on a valid/ready command stream: save, restore, flush, saved and restored. Each accepted command produces exactly one response on a valid/ready response stream. That response either reports success, with the counters and window index updated, or carries a trap type for a spill, fill or clean-window trap, with no state changed.

Software sees the window index in reversed numbering: window 0 as software sees it is the highest internal window. Writes go through the same reversal, and a written value outside the ring is first reduced modulo the window count. Software may also load any single counter and the selector word through plain control pins. The block moves no register contents; it only decides and tracks.

Back-pressure: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the single response slot is empty or is being drained in the same cycle. A response stays valid and unchanged until it is taken with `rsp_ready`.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset, can-save equals NWIN-2, can-restore, other-windows and clean-windows are 0, the internal window index is 0 (so `cwp_rd` reads NWIN-1), and no response is valid.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are high, with `cmd_ready` high exactly when no response is pending or `rsp_ready` is high. Every accepted command yields one response that becomes valid on the next cycle. A response held with `rsp_ready` low keeps its trap flag and trap type.
- R3: A save (op code 0) with can-save non-zero and clean-windows not equal to can-restore succeeds. It decrements can-save, increments can-restore and steps the internal index down by one modulo NWIN, so `cwp_rd` goes up by one modulo NWIN. The response has trap flag 0 and trap type 0.
- R4: A save with can-save equal to 0 returns a trap with type 0x080 ORed with the selector tail of R5, and changes no counter.
- R5: The selector tail depends on other-windows. If other-windows is non-zero, the tail is bit 5 set with selector bits 5:3 placed in trap type bits 4:2. If other-windows is zero, the tail is selector bits 2:0 placed in trap type bits 4:2. Bits 1:0 of the tail are always 0.
- R6: A save with can-save non-zero but clean-windows equal to can-restore returns trap type 0x024 and changes no counter.
- R7: A restore (op code 1) with can-restore equal to 0 returns trap type 0x0C0 ORed with the tail of R5. Otherwise it increments can-save, decrements can-restore and steps the internal index up by one modulo NWIN.
- R8: A flush (op code 2) returns trap type 0x080 ORed with the tail of R5 whenever can-save differs from NWIN-2, and no trap otherwise. It never changes any counter.
- R9: A saved command (op code 3) increments can-save. It then decrements can-restore if other-windows is 0, and decrements other-windows otherwise. It never traps.
- R10: A restored command (op code 4) increments can-restore. It increments clean-windows only while clean-windows is below NWIN-1. It decrements can-save if other-windows is 0, and decrements other-windows otherwise. It never traps.
- R11: `cwp_rd` reads NWIN-1 minus the internal index. A write of value v sets the internal index to NWIN-1-(v mod NWIN), and such a write wins over any index step from a command in the same cycle.
- R12: A selector write takes effect on the next cycle, is read back on `wstate_rd`, and is used for commands accepted after it. A counter load (`cnt_wr_sel` 0 can-save, 1 can-restore, 2 other-windows, 3 clean-windows) replaces that counter's next value, even over a command update in the same cycle. Counter arithmetic wraps modulo 2 to the counter width.
- R13: Op codes 5 to 7 are accepted, give a response with trap flag 0 and trap type 0, and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Command code (0 save, 1 restore, 2 flush, 3 saved, 4 restored) |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumer takes the response |
| rsp_trap | output | 1 | Command trapped |
| rsp_tt | output | 9 | Trap type, 0 when no trap |
| cwp_wr_en | input | 1 | Write the software window index |
| cwp_wr_data | input | 8 | Software window index value |
| cwp_rd | output | 8 | Software window index (reversed) |
| wstate_wr_en | input | 1 | Write the trap selector word |
| wstate_wr_data | input | 6 | Trap selector value |
| wstate_rd | output | 6 | Trap selector word |
| cnt_wr_en | input | 1 | Load one counter |
| cnt_wr_sel | input | 2 | Counter to load |
| cnt_wr_data | input | CW | Counter load value |
| cansave | output | CW | Windows free for save |
| canrestore | output | CW | Windows holding restorable frames |
| otherwin | output | CW | Windows owned by another context |
| cleanwin | output | CW | Clean windows |

## Verification
The bench builds the block with NWIN set to 6, a ring size that is not a power of two. With this size the explicit index wrap at 0 and at 5 is exercised, and so is the true modulo reduction of written indices from 6 to 255. A counter width of 3 bits leaves headroom above the ring size, so the clean-windows cap at 5 and the can-save value of 4 checked by flush are both reached after only a few commands. Loading other-windows with a non-zero value brings the alternate selector tail within reach. Random back-pressure on the response stream exercises the held-response and stalled-command cases.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int TT_W    = 9;
  localparam int SWCWP_W = 8;
  localparam int WS_W    = 6;

  typedef enum logic [2:0] {
    OP_SAVE     = 3'd0,
    OP_RESTORE  = 3'd1,
    OP_FLUSH    = 3'd2,
    OP_SAVED    = 3'd3,
    OP_RESTORED = 3'd4
  } win_op_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_SPILL = 2'd1,
    TK_FILL  = 2'd2,
    TK_CLEAN = 2'd3
  } trap_kind_e;

  typedef enum logic [1:0] {
    SEL_CANSAVE    = 2'd0,
    SEL_CANRESTORE = 2'd1,
    SEL_OTHERWIN   = 2'd2,
    SEL_CLEANWIN   = 2'd3
  } cnt_sel_e;

  typedef struct packed {
    logic            trap;
    logic [TT_W-1:0] tt;
  } win_rsp_t;
endpackage

// File: rtl/regwin_tt_enc.sv
module regwin_tt_enc
  import regwin_pkg::*;
#(
  parameter logic [TT_W-1:0] SPILL_TT = 9'h080,
  parameter logic [TT_W-1:0] FILL_TT  = 9'h0C0,
  parameter logic [TT_W-1:0] CLEAN_TT = 9'h024
) (
  input  trap_kind_e        kind,
  input  logic              other_nz,
  input  logic [WS_W-1:0]   wstate,
  output logic [TT_W-1:0]   tt
);
  logic [2:0]      sub;
  logic [TT_W-1:0] tail;

  // R5: selector field choice depends on foreign-window occupancy
  always_comb begin
    sub  = other_nz ? wstate[5:3] : wstate[2:0];
    tail = TT_W'({other_nz, sub, 2'b00});
  end

  always_comb begin
    unique case (kind)
      TK_SPILL: tt = SPILL_TT | tail;
      TK_FILL:  tt = FILL_TT | tail;
      TK_CLEAN: tt = CLEAN_TT;
      default:  tt = '0;
    endcase
  end
endmodule

// File: rtl/regwin_cwp_map.sv
module regwin_cwp_map
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic [SWCWP_W-1:0] sw_wr,
  output logic [CW-1:0]      idx_wr,
  input  logic [CW-1:0]      idx_cur,
  output logic [SWCWP_W-1:0] sw_rd
);
  localparam logic [CW-1:0] TOP_IDX = CW'(NWIN - 1);

  logic [CW-1:0] reduced;

  // R11: out-of-ring values fold back modulo the ring size
  assign reduced = CW'(sw_wr % SWCWP_W'(NWIN));
  assign idx_wr  = TOP_IDX - reduced;
  assign sw_rd   = SWCWP_W'(TOP_IDX - idx_cur);
endmodule

// File: rtl/regwin_rsp_slot.sv
module regwin_rsp_slot #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  // R2: one entry, refilled in the same cycle it drains
  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/regwin_core.sv
module regwin_core
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [2:0]    op,
  input  logic          cwp_wr_en,
  input  logic [CW-1:0] cwp_wr_idx,
  input  logic          cnt_wr_en,
  input  logic [1:0]    cnt_wr_sel,
  input  logic [CW-1:0] cnt_wr_data,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore,
  output logic [CW-1:0] otherwin,
  output logic [CW-1:0] cleanwin,
  output logic [CW-1:0] cwp,
  output trap_kind_e    kind
);
  localparam logic [CW-1:0] TOP_IDX   = CW'(NWIN - 1);
  localparam logic [CW-1:0] FULL_SAVE = CW'(NWIN - 2);
  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam bit            POW2      = (NWIN & (NWIN - 1)) == 0;

  logic [CW-1:0] cs_q, cr_q, ow_q, cl_q, cwp_q;
  logic [CW-1:0] cs_n, cr_n, ow_n, cl_n, cwp_n;
  logic [CW-1:0] cwp_dn, cwp_up;

  // Ring step: free wrap for power-of-two rings, explicit wrap otherwise
  generate
    if (POW2) begin : g_wrap_free
      assign cwp_dn = cwp_q - ONE;
      assign cwp_up = cwp_q + ONE;
    end else begin : g_wrap_cmp
      assign cwp_dn = (cwp_q == '0) ? TOP_IDX : cwp_q - ONE;
      assign cwp_up = (cwp_q == TOP_IDX) ? '0 : cwp_q + ONE;
    end
  endgenerate

  // Trap decision from current state (R4, R6, R7, R8)
  always_comb begin
    kind = TK_NONE;
    case (op)
      OP_SAVE: begin
        if (cs_q == '0)       kind = TK_SPILL;
        else if (cl_q == cr_q) kind = TK_CLEAN;
      end
      OP_RESTORE: begin
        if (cr_q == '0) kind = TK_FILL;
      end
      OP_FLUSH: begin
        if (cs_q != FULL_SAVE) kind = TK_SPILL;
      end
      default: kind = TK_NONE;
    endcase
  end

  // Next-state: command update, then software loads override
  always_comb begin
    cs_n  = cs_q;
    cr_n  = cr_q;
    ow_n  = ow_q;
    cl_n  = cl_q;
    cwp_n = cwp_q;
    if (fire && kind == TK_NONE) begin
      case (op)
        OP_SAVE: begin      // R3
          cs_n  = cs_q - ONE;
          cr_n  = cr_q + ONE;
          cwp_n = cwp_dn;
        end
        OP_RESTORE: begin   // R7
          cs_n  = cs_q + ONE;
          cr_n  = cr_q - ONE;
          cwp_n = cwp_up;
        end
        OP_SAVED: begin     // R9
          cs_n = cs_q + ONE;
          if (ow_q == '0) cr_n = cr_q - ONE;
          else            ow_n = ow_q - ONE;
        end
        OP_RESTORED: begin  // R10
          cr_n = cr_q + ONE;
          if (cl_q < TOP_IDX) cl_n = cl_q + ONE;
          if (ow_q == '0) cs_n = cs_q - ONE;
          else            ow_n = ow_q - ONE;
        end
        default: ;          // flush success and unused codes: no change (R8, R13)
      endcase
    end
    if (cwp_wr_en) cwp_n = cwp_wr_idx;   // R11
    if (cnt_wr_en) begin                  // R12
      case (cnt_wr_sel)
        SEL_CANSAVE:    cs_n = cnt_wr_data;
        SEL_CANRESTORE: cr_n = cnt_wr_data;
        SEL_OTHERWIN:   ow_n = cnt_wr_data;
        default:        cl_n = cnt_wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= FULL_SAVE;   // R1
      cr_q  <= '0;
      ow_q  <= '0;
      cl_q  <= '0;
      cwp_q <= '0;
    end else begin
      cs_q  <= cs_n;
      cr_q  <= cr_n;
      ow_q  <= ow_n;
      cl_q  <= cl_n;
      cwp_q <= cwp_n;
    end
  end

  assign cansave    = cs_q;
  assign canrestore = cr_q;
  assign otherwin   = ow_q;
  assign cleanwin   = cl_q;
  assign cwp        = cwp_q;
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int              NWIN     = 8,
  parameter logic [TT_W-1:0] SPILL_TT = 9'h080,
  parameter logic [TT_W-1:0] FILL_TT  = 9'h0C0,
  parameter logic [TT_W-1:0] CLEAN_TT = 9'h024,
  localparam int             CW       = $clog2(NWIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_trap,
  output logic [TT_W-1:0]    rsp_tt,
  input  logic               cwp_wr_en,
  input  logic [SWCWP_W-1:0] cwp_wr_data,
  output logic [SWCWP_W-1:0] cwp_rd,
  input  logic               wstate_wr_en,
  input  logic [WS_W-1:0]    wstate_wr_data,
  output logic [WS_W-1:0]    wstate_rd,
  input  logic               cnt_wr_en,
  input  logic [1:0]         cnt_wr_sel,
  input  logic [CW-1:0]      cnt_wr_data,
  output logic [CW-1:0]      cansave,
  output logic [CW-1:0]      canrestore,
  output logic [CW-1:0]      otherwin,
  output logic [CW-1:0]      cleanwin
);
  localparam int RSP_W = $bits(win_rsp_t);

  logic            fire;
  logic [CW-1:0]   cwp_idx;
  logic [CW-1:0]   cwp_wr_idx;
  trap_kind_e      kind;
  logic [TT_W-1:0] tt;
  logic [WS_W-1:0] wstate_q;
  win_rsp_t        rsp_in, rsp_out;

  assign fire = cmd_valid && cmd_ready;

  regwin_core #(.NWIN(NWIN), .CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .op         (cmd_op),
    .cwp_wr_en  (cwp_wr_en),
    .cwp_wr_idx (cwp_wr_idx),
    .cnt_wr_en  (cnt_wr_en),
    .cnt_wr_sel (cnt_wr_sel),
    .cnt_wr_data(cnt_wr_data),
    .cansave    (cansave),
    .canrestore (canrestore),
    .otherwin   (otherwin),
    .cleanwin   (cleanwin),
    .cwp        (cwp_idx),
    .kind       (kind)
  );

  regwin_cwp_map #(.NWIN(NWIN), .CW(CW)) u_map (
    .sw_wr  (cwp_wr_data),
    .idx_wr (cwp_wr_idx),
    .idx_cur(cwp_idx),
    .sw_rd  (cwp_rd)
  );

  regwin_tt_enc #(.SPILL_TT(SPILL_TT), .FILL_TT(FILL_TT), .CLEAN_TT(CLEAN_TT)) u_enc (
    .kind    (kind),
    .other_nz(otherwin != '0),
    .wstate  (wstate_q),
    .tt      (tt)
  );

  // R12: selector register, used by commands from the next cycle on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wstate_q <= '0;
    else if (wstate_wr_en) wstate_q <= wstate_wr_data;
  end
  assign wstate_rd = wstate_q;

  assign rsp_in.trap = (kind != TK_NONE);
  assign rsp_in.tt   = tt;

  regwin_rsp_slot #(.W(RSP_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cmd_valid),
    .in_ready (cmd_ready),
    .in_data  (rsp_in),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (rsp_out)
  );

  assign rsp_trap = rsp_out.trap;
  assign rsp_tt   = rsp_out.tt;
endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk #(
  parameter int       NWIN     = 8,
  parameter logic [8:0] SPILL_TT = 9'h080,
  parameter int       CW       = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic          rsp_trap,
  input logic [8:0]    rsp_tt,
  input logic          cwp_wr_en,
  input logic [7:0]    cwp_rd,
  input logic          cnt_wr_en,
  input logic [CW-1:0] cansave,
  input logic [CW-1:0] canrestore,
  input logic [CW-1:0] otherwin,
  input logic [CW-1:0] cleanwin
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid); // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_trap) && $stable(rsp_tt)); // R2

  AST_SPILL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 3'd0 && cansave == '0 |=> rsp_trap && ((rsp_tt & ~9'h03C) == SPILL_TT)); // R4

  AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    take && !cnt_wr_en |=> !rsp_trap || (cansave == $past(cansave) && canrestore == $past(canrestore)
                                         && otherwin == $past(otherwin) && cleanwin == $past(cleanwin))); // R6

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 3'd0 && !cwp_wr_en && cansave != '0 && cleanwin != canrestore
    |=> int'(cwp_rd) == (int'($past(cwp_rd)) + 1) % NWIN); // R3

  AST_FLUSH_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_op == 3'd2 && int'(cansave) != NWIN - 2 |=> rsp_trap); // R8

  AST_CLEAN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> int'(cleanwin) <= NWIN - 1 || cleanwin == $past(cleanwin)); // R10

  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp_rd) < NWIN); // R11
endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NWIN(NWIN), .SPILL_TT(SPILL_TT), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_trap  (rsp_trap),
  .rsp_tt    (rsp_tt),
  .cwp_wr_en (cwp_wr_en),
  .cwp_rd    (cwp_rd),
  .cnt_wr_en (cnt_wr_en),
  .cansave   (cansave),
  .canrestore(canrestore),
  .otherwin  (otherwin),
  .cleanwin  (cleanwin)
);

// File: tb/tb_regwin_ctrl.sv
module tb_regwin_ctrl;
  localparam int PERIOD = 10;
  localparam int NW     = 6;
  localparam int CW     = $clog2(NW);
  localparam int MASK   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_trap;
  logic [8:0]    rsp_tt;
  logic          cwp_wr_en = 1'b0;
  logic [7:0]    cwp_wr_data = '0;
  logic [7:0]    cwp_rd;
  logic          wstate_wr_en = 1'b0;
  logic [5:0]    wstate_wr_data = '0;
  logic [5:0]    wstate_rd;
  logic          cnt_wr_en = 1'b0;
  logic [1:0]    cnt_wr_sel = '0;
  logic [CW-1:0] cnt_wr_data = '0;
  logic [CW-1:0] cansave, canrestore, otherwin, cleanwin;

  regwin_ctrl #(.NWIN(NW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_trap(rsp_trap), .rsp_tt(rsp_tt),
    .cwp_wr_en(cwp_wr_en), .cwp_wr_data(cwp_wr_data), .cwp_rd(cwp_rd),
    .wstate_wr_en(wstate_wr_en), .wstate_wr_data(wstate_wr_data), .wstate_rd(wstate_rd),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel), .cnt_wr_data(cnt_wr_data),
    .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin), .cleanwin(cleanwin)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  int    ms, mr, mo, mc, mcwp, mws, mtt;
  bit    mrv, mtrap, mrdy;
  int    tail;
  string mtag = "R1";

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = NW - 2; mr = 0; mo = 0; mc = 0; mcwp = 0; mws = 0;
      mrv = 0; mtrap = 0; mtt = 0; mtag = "R1";
    end else begin
      mrdy = !mrv || rsp_ready;
      if (cmd_valid && mrdy) begin
        tail  = (mo != 0) ? (32 | (((mws >> 3) & 7) << 2)) : ((mws & 7) << 2);
        mtrap = 0; mtt = 0;
        case (int'(cmd_op))
          0: if (ms == 0) begin mtrap = 1; mtt = 'h080 | tail; mtag = "R4 R5"; end
             else if (mc == mr) begin mtrap = 1; mtt = 'h024; mtag = "R6"; end
             else begin ms = (ms - 1) & MASK; mr = (mr + 1) & MASK; mcwp = (mcwp + NW - 1) % NW; mtag = "R3"; end
          1: if (mr == 0) begin mtrap = 1; mtt = 'h0C0 | tail; mtag = "R7 R5"; end
             else begin ms = (ms + 1) & MASK; mr = (mr - 1) & MASK; mcwp = (mcwp + 1) % NW; mtag = "R7"; end
          2: begin mtag = "R8"; if (ms != NW - 2) begin mtrap = 1; mtt = 'h080 | tail; end end
          3: begin ms = (ms + 1) & MASK; if (mo == 0) mr = (mr - 1) & MASK; else mo = (mo - 1) & MASK; mtag = "R9"; end
          4: begin mr = (mr + 1) & MASK; if (mc < NW - 1) mc = mc + 1;
                   if (mo == 0) ms = (ms - 1) & MASK; else mo = (mo - 1) & MASK; mtag = "R10"; end
          default: mtag = "R13";
        endcase
        mrv = 1;
      end else if (rsp_ready) begin
        mrv = 0;
      end
      if (cwp_wr_en) mcwp = NW - 1 - (int'(cwp_wr_data) % NW);
      if (wstate_wr_en) mws = int'(wstate_wr_data);
      if (cnt_wr_en) case (int'(cnt_wr_sel))
        0: ms = int'(cnt_wr_data);
        1: mr = int'(cnt_wr_data);
        2: mo = int'(cnt_wr_data);
        default: mc = int'(cnt_wr_data);
      endcase
    end
  end

  task automatic compare_all();
    chk("R2", "cmd_ready", int'(cmd_ready), int'(!mrv || rsp_ready));
    chk("R2", "rsp_valid", int'(rsp_valid), int'(mrv));
    if (mrv) begin
      chk(mtag, "rsp_trap", int'(rsp_trap), int'(mtrap));
      chk(mtag, "rsp_tt", int'(rsp_tt), mtt);
    end
    chk(mtag, "cansave", int'(cansave), ms);
    chk(mtag, "canrestore", int'(canrestore), mr);
    chk(mtag, "otherwin", int'(otherwin), mo);
    chk(mtag, "cleanwin", int'(cleanwin), mc);
    chk("R11", "cwp_rd", int'(cwp_rd), NW - 1 - mcwp);
    chk("R12", "wstate_rd", int'(wstate_rd), mws);
  endtask

  // One cycle: drive at negedge, compare at the following negedge
  task automatic go(input bit v, input int op, input bit rr);
    cmd_valid = v; cmd_op = 3'(op); rsp_ready = rr;
    @(negedge clk);
    compare_all();
    cmd_valid = 0; cwp_wr_en = 0; wstate_wr_en = 0; cnt_wr_en = 0;
  endtask

  task automatic load_cnt(input int sel, input int val);
    cnt_wr_en = 1; cnt_wr_sel = 2'(sel); cnt_wr_data = CW'(val);
    go(0, 0, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset cansave", int'(cansave), NW - 2);
    chk("R1", "reset canrestore", int'(canrestore), 0);
    chk("R1", "reset otherwin", int'(otherwin), 0);
    chk("R1", "reset cleanwin", int'(cleanwin), 0);
    chk("R1", "reset cwp_rd", int'(cwp_rd), NW - 1);
    chk("R1", "reset rsp_valid", int'(rsp_valid), 0);

    go(1, 2, 1);                       // R8 flush at full can-save: no trap
    go(1, 0, 1);                       // R6 clean-window trap
    load_cnt(3, NW - 1);               // R12 clean-windows loaded
    wstate_wr_en = 1; wstate_wr_data = 6'b101_011; go(0, 0, 1);
    for (int i = 0; i < NW - 2; i++) go(1, 0, 1);   // R3 successful saves
    go(1, 0, 1);                       // R4 spill, tail from low selector bits
    go(1, 2, 1);                       // R8 flush spill
    load_cnt(2, 2);                    // other-windows non-zero
    go(1, 0, 1);                       // R5 spill with other flag
    go(1, 1, 1);                       // R5 fill tail path via restore success first
    go(1, 3, 1);                       // R9 saved, other-windows path
    go(1, 4, 1);                       // R10 restored, other-windows path
    go(1, 4, 1);                       // R10 restored, can-save path
    for (int i = 0; i < 8; i++) go(1, 1, 1);        // R7 restores down to fill
    cwp_wr_en = 1; cwp_wr_data = 8'd200; go(0, 0, 1); // R11 modulo write
    cwp_wr_en = 1; cwp_wr_data = 8'd5; go(1, 0, 1);   // R11 write wins over step
    go(1, 6, 1);                       // R13 unused op code
    go(1, 5, 0);                       // R2 response held
    go(1, 3, 0);
    go(1, 3, 0);
    go(0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) begin cwp_wr_en = 1; cwp_wr_data = 8'($urandom_range(0, 255)); end
      if ($urandom_range(0, 19) == 0) begin wstate_wr_en = 1; wstate_wr_data = 6'($urandom_range(0, 63)); end
      if ($urandom_range(0, 19) == 0) begin
        cnt_wr_en = 1; cnt_wr_sel = 2'($urandom_range(0, 3)); cnt_wr_data = CW'($urandom_range(0, NW - 1));
      end
      go($urandom_range(0, 9) < 7, $urandom_range(0, 7), $urandom_range(0, 3) != 0);
    end
    finish_run();
  end
endmodule